// File: doc/BRIEF.md
# Two-Wire Register Access Master

This block is a bus master that reads and writes 16-bit registers in a slave device over a two-wire link. One wire is a clock that only the master drives. The other is a data line that both sides share. The electrical levels look like a management-data bus, but the framing is its own. A transaction opens with a multi-pulse start pattern and closes with a stop pattern that ends in two extra clock pulses, after which both pads are released. Every byte is sent most significant bit first.

The host raises `req` for one cycle while the block is idle. With the request it gives a read/write flag, a 16-bit address, 16-bit write data and a flag that skips the acknowledge after the last write byte. That skip is needed when the write resets the slave, because the slave then never answers. The block raises `busy` until it returns a one-cycle `done` together with `err` and, for reads, `rdata`.

Each byte the master writes is followed by one acknowledge bit that the master reads back. A 1 in that bit is polled again, a bounded number of times. When the last permitted poll fails, the block abandons the remaining bytes and still sends stop. Every step on the wire waits for one half-period delay, which a prescaler derives from the system clock. The data input passes through a two-flop synchronizer before it is sampled.

Top module: `twowire_reg_master`

## Requirements
- R1: After a request is accepted, both pads are driven with the clock low and the data line high. The start pattern then produces two clock rising edges with the data line at 1. The data line falls exactly once while the clock is high, and that fall comes before the first command bit.
- R2: Every byte the master sends is shifted out most significant bit first. Each bit is set up while the clock is low and is held on the data line while the clock is high.
- R3: After each byte the master sends, it releases the data line and reads one acknowledge bit, where 0 means acknowledged. A 1 is polled again. Up to 5 failed polls are tolerated. A 6th consecutive failed poll aborts the transaction.
- R4: A read sends the command byte `CMD_RD`, then the low address byte, then the high address byte. It then reads the low data byte and answers it with a 0 bit, then reads the high data byte and answers it with a 1 bit. `rdata` equals {high byte, low byte}.
- R5: A write sends the command byte `CMD_WR`, then the address low and high bytes, then the data low and high bytes. The slave acknowledges each of these bytes.
- R6: When `no_ack` is set on a write, no acknowledge slot follows the fifth byte, and stop comes directly after it.
- R7: On an acknowledge abort, no further bytes are sent. The stop pattern is still issued, and `done` then arrives with `err` = 1. A transaction that completes normally reports `err` = 0.
- R8: The stop pattern produces clock rising edges with data values 0, 1, 1. The data line rises exactly once while the clock is high. After stop, both output enables are low whenever the block is idle.
- R9: `busy` is high from the cycle after an accepted request until `done`. `done` lasts exactly one cycle, and `busy` is low in that cycle. A `req` raised while busy is ignored: it neither alters the ongoing transfer nor starts another one.
- R10: Each clock high phase on the wire lasts at least `HALF_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, accepted only when idle |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Register address |
| wdata | input | 16 | Write data |
| no_ack | input | 1 | Skip the acknowledge after the final write byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Acknowledge timeout occurred, valid with done |
| rdata | output | 16 | Read data, valid with done |
| sck_o | output | 1 | Clock pad output value |
| sck_oe | output | 1 | Clock pad output enable |
| sda_o | output | 1 | Data pad output value |
| sda_oe | output | 1 | Data pad output enable |
| sda_i | input | 1 | Data pad input (asynchronous) |

## Verification
The bench acts as the slave and decodes every master-driven bit, along with the start and stop marks, from the pad activity. It sweeps a write over all five acknowledge positions with 1, 5 and 6 failed polls, and a read over its three acknowledge positions. This separates a tolerated retry from an off-by-one abort and shows exactly which bytes an abort truncates. Clean reads and writes use address and data patterns of all zeros, all ones and alternating bits, which expose bit-order and byte-order swaps. `no_ack` writes, including one that aborts early, and a stray request during a transfer cover the skipped slot and the ignored request.

// File: rtl/twowire_reg_master.sv
module twowire_reg_master #(
  parameter logic [7:0] CMD_RD   = 8'hA9,
  parameter logic [7:0] CMD_WR   = 8'hA8,
  parameter int         HALF_DIV = 4,
  parameter int         RETRY_MAX = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        rd_wr,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  input  logic        no_ack,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  output logic        sck_o,
  output logic        sck_oe,
  output logic        sda_o,
  output logic        sda_oe,
  input  logic        sda_i
);
  localparam int CW = $clog2(HALF_DIV + 1) + 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);
  localparam logic [3:0] RMAX = 4'(RETRY_MAX);

  typedef enum logic [2:0] {S_IDLE, S_START, S_WR, S_SACK, S_RD, S_MACK, S_STOP} st_t;
  st_t state;

  logic [CW-1:0] cnt;
  logic [2:0]  ph, bitn, byte_i;
  logic [3:0]  retries;
  logic [7:0]  sh;
  logic        rw_q, noack_q;
  logic [15:0] addr_q, wdata_q;
  logic        sda_m, sda_s;

  assign busy = (state != S_IDLE);
  wire   tick = busy && (cnt == CNT_TOP);

  function automatic logic [7:0] pick(input logic [2:0] i);
    case (i)
      3'd0:    pick = rw_q ? CMD_RD : CMD_WR;
      3'd1:    pick = addr_q[7:0];
      3'd2:    pick = addr_q[15:8];
      3'd3:    pick = wdata_q[7:0];
      default: pick = wdata_q[15:8];
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sda_m, sda_s} <= 2'b11;
    else        {sda_m, sda_s} <= {sda_i, sda_m};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; ph <= '0; bitn <= '0; byte_i <= '0;
      retries <= '0; sh <= '0; rw_q <= 1'b0; noack_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0; done <= 1'b0; err <= 1'b0; rdata <= '0;
      sck_o <= 1'b0; sck_oe <= 1'b0; sda_o <= 1'b1; sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        cnt <= '0;
        if (req) begin
          rw_q <= rd_wr; addr_q <= addr; wdata_q <= wdata; noack_q <= no_ack;
          sck_o <= 1'b0; sda_o <= 1'b1; sck_oe <= 1'b1; sda_oe <= 1'b1;
          err <= 1'b0; ph <= '0; state <= S_START;
        end
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          ph <= ph + 3'd1;
          case (state)
            S_START:
              case (ph)
                3'd0: sck_o <= 1'b1;
                3'd1: sck_o <= 1'b0;
                3'd2: sck_o <= 1'b1;
                3'd3: sda_o <= 1'b0;
                3'd4: sck_o <= 1'b0;
                default: begin
                  sda_o <= 1'b1; state <= S_WR; ph <= '0;
                  bitn <= '0; byte_i <= '0; sh <= pick(3'd0);
                end
              endcase
            S_WR:
              case (ph)
                3'd0: sda_o <= sh[7];
                3'd1: sck_o <= 1'b1;
                default: begin
                  sck_o <= 1'b0; sh <= {sh[6:0], 1'b0}; ph <= '0; bitn <= bitn + 3'd1;
                  if (bitn == 3'd7) begin
                    if (!rw_q && byte_i == 3'd4 && noack_q) state <= S_STOP;
                    else begin state <= S_SACK; retries <= '0; end
                  end
                end
              endcase
            S_SACK:
              case (ph)
                3'd0: sda_oe <= 1'b0;
                3'd1: sck_o <= 1'b1;
                default: begin
                  sck_o <= 1'b0; ph <= '0;
                  if (!sda_s) begin
                    sda_oe <= 1'b1; sda_o <= 1'b0; byte_i <= byte_i + 3'd1; bitn <= '0;
                    if (rw_q && byte_i == 3'd2)       state <= S_RD;
                    else if (!rw_q && byte_i == 3'd4) state <= S_STOP;
                    else begin state <= S_WR; sh <= pick(byte_i + 3'd1); end
                  end else if (retries == RMAX) begin
                    err <= 1'b1; sda_oe <= 1'b1; sda_o <= 1'b0; state <= S_STOP;
                  end else retries <= retries + 4'd1;
                end
              endcase
            S_RD:
              case (ph)
                3'd0: sda_oe <= 1'b0;
                3'd1: sck_o <= 1'b1;
                default: begin
                  sck_o <= 1'b0; ph <= '0; sh <= {sh[6:0], sda_s}; bitn <= bitn + 3'd1;
                  if (bitn == 3'd7) begin
                    sda_oe <= 1'b1; sda_o <= 1'b0; state <= S_MACK;
                    if (byte_i == 3'd3) rdata[7:0]  <= {sh[6:0], sda_s};
                    else                rdata[15:8] <= {sh[6:0], sda_s};
                  end
                end
              endcase
            S_MACK:
              case (ph)
                3'd0: sda_o <= (byte_i == 3'd4);
                3'd1: sck_o <= 1'b1;
                default: begin
                  sck_o <= 1'b0; ph <= '0;
                  if (byte_i == 3'd4) state <= S_STOP;
                  else begin byte_i <= 3'd4; bitn <= '0; state <= S_RD; end
                end
              endcase
            S_STOP:
              case (ph)
                3'd0: begin sda_o <= 1'b0; sck_o <= 1'b1; end
                3'd1: sda_o <= 1'b1;
                3'd2: ;
                3'd3: sck_o <= 1'b0;
                3'd4: sck_o <= 1'b1;
                3'd5: sck_o <= 1'b0;
                3'd6: sck_o <= 1'b1;
                default: begin
                  sck_oe <= 1'b0; sda_oe <= 1'b0; state <= S_IDLE; done <= 1'b1;
                end
              endcase
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R9
  AST_ACCEPT_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(req)); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!sck_oe && !sda_oe)); // R8
  AST_ACK_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n) (state == S_SACK && sck_o) |-> !sda_oe); // R3
  AST_WR_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (state == S_WR && $past(state) == S_WR && $past(sck_o) && sck_o) |-> $stable(sda_o)); // R2
endmodule

// File: tb/twowire_reg_master_tb.sv
module twowire_reg_master_tb;
  localparam int HALF = 2;
  localparam logic [7:0] CRD = 8'hA9, CWR = 8'hA8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rd_wr = 1'b0, no_ack = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic busy, done, err, sck_o, sck_oe, sda_o, sda_oe, sda_i;
  logic [15:0] rdata;

  always #4 clk = ~clk;

  twowire_reg_master #(.CMD_RD(CRD), .CMD_WR(CWR), .HALF_DIV(HALF), .RETRY_MAX(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rd_wr(rd_wr), .addr(addr), .wdata(wdata),
    .no_ack(no_ack), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .sck_o(sck_o), .sck_oe(sck_oe), .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i));

  int checks = 0, fails = 0;
  bit mbits[0:255]; int mn = 0;
  bit exp_b[0:255]; int en = 0;
  bit resp[0:255];  int rn = 0;
  int slot = 0, starts = 0, stops = 0, hi_run = 0, min_hi = 1000;
  logic p_sck = 0, p_sda = 1, p_sckoe = 0, p_sdaoe = 0;

  assign sda_i = (slot < rn) ? resp[slot] : 1'b1;

  always @(negedge clk) begin
    if (sck_oe && p_sckoe) begin
      if (!p_sck && sck_o && sda_oe && mn < 256) begin mbits[mn] = sda_o; mn++; end
      if (p_sck && !sck_o && !p_sdaoe) slot++;
      if (p_sck && sck_o && p_sdaoe && sda_oe && p_sda && !sda_o) starts++;
      if (p_sck && sck_o && p_sdaoe && sda_oe && !p_sda && sda_o) stops++;
    end
    if (sck_oe && sck_o) hi_run++;
    else if (hi_run > 0) begin if (hi_run < min_hi) min_hi = hi_run; hi_run = 0; end
    p_sck = sck_o; p_sda = sda_o; p_sckoe = sck_oe; p_sdaoe = sda_oe;
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, ex);
    end
  endtask

  task automatic pe(input bit b); exp_b[en] = b; en++; endtask
  task automatic pbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) pe(v[i]);
  endtask
  task automatic pr(input bit b); resp[rn] = b; rn++; endtask

  task automatic run(input bit rw, input logic [15:0] a, input logic [15:0] d, input bit na,
                     input int fp, input int fv, input logic [15:0] rv, input bit poke);
    logic [7:0] seq [0:4];
    int nb, nack;
    bit abort, got, e_err;
    logic [15:0] g_rd;
    bit g_err;
    bit same;
    seq[0] = rw ? CRD : CWR; seq[1] = a[7:0]; seq[2] = a[15:8]; seq[3] = d[7:0]; seq[4] = d[15:8];
    nb = rw ? 3 : 5;
    nack = rw ? 3 : (na ? 4 : 5);
    en = 0; rn = 0; mn = 0; slot = 0; starts = 0; stops = 0; min_hi = 1000; hi_run = 0;
    abort = 0;
    pe(1); pe(1);
    for (int i = 0; i < nb; i++) begin
      pbyte(seq[i]);
      if (i < nack) begin
        int f = (i == fp) ? fv : 0;
        if (f > 5) begin
          for (int k = 0; k < 6; k++) pr(1);
          abort = 1;
        end else begin
          for (int k = 0; k < f; k++) pr(1);
          pr(0);
        end
      end
      if (abort) break;
    end
    if (rw && !abort) begin
      for (int i = 7; i >= 0; i--) pr(rv[i]);
      for (int i = 15; i >= 8; i--) pr(rv[i]);
      pe(0); pe(1);
    end
    pe(0); pe(1); pe(1);
    e_err = abort;

    @(negedge clk);
    req = 1; rd_wr = rw; addr = a; wdata = d; no_ack = na;
    @(negedge clk);
    req = 0; addr = ~a; wdata = ~d; rd_wr = ~rw; no_ack = ~na;
    chk(busy === 1'b1, "R9", "busy after accept", busy, 1);
    got = 0; g_err = 0; g_rd = '0;
    for (int t = 0; t < 20000; t++) begin
      if (poke && t == 40) req = 1;
      if (poke && t == 41) req = 0;
      @(negedge clk);
      if (done) begin got = 1; g_err = err; g_rd = rdata; break; end
    end
    chk(got, "R9", "done seen", got, 1);
    chk(busy === 1'b0, "R9", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(g_err == e_err, "R7", "err flag", g_err, e_err);
    if (rw && !abort) chk(g_rd == rv, "R4", "rdata", g_rd, rv);
    chk(mn == en, rw ? "R4" : "R5", "master bit count", mn, en);
    same = 1;
    for (int i = 0; i < en && i < mn; i++) if (mbits[i] != exp_b[i]) same = 0;
    chk(same, "R2", "master bit stream", same, 1);
    chk(slot == rn, na ? "R6" : "R3", "slave slots used", slot, rn);
    chk(starts == 1, "R1", "start marks", starts, 1);
    chk(stops == 1, "R8", "stop marks", stops, 1);
    chk(sck_oe === 1'b0 && sda_oe === 1'b0, "R8", "pads released", {sck_oe, sda_oe}, 0);
    chk(min_hi >= HALF, "R10", "min clock high", min_hi, HALF);
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(busy === 1'b0, "R9", "stray req not started", busy, 0);
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R9", "reset busy/done", {busy, done}, 0);
    chk(sck_oe === 1'b0 && sda_oe === 1'b0, "R8", "reset pads", {sck_oe, sda_oe}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R5 R4 clean patterns
    run(0, 16'h0000, 16'hFFFF, 0, -1, 0, 16'h0, 0);
    run(0, 16'hA55A, 16'h0180, 0, -1, 0, 16'h0, 0);
    run(1, 16'hFFFF, 16'h0, 0, -1, 0, 16'h1E87, 0);
    run(1, 16'h0000, 16'h0, 0, -1, 0, 16'hA55A, 0);
    run(1, 16'h8001, 16'h0, 0, -1, 0, 16'hFF00, 0);
    // R3 R7 sweep of ack positions and poll counts
    for (int p = 0; p < 5; p++)
      for (int k = 0; k < 3; k++) begin
        int fv = (k == 0) ? 1 : ((k == 1) ? 5 : 6);
        run(0, 16'h1234 * 16'(p + 1) ^ 16'(k), 16'hC3A5 ^ 16'(p * 7), 0, p, fv, 16'h0, 0);
      end
    for (int p = 0; p < 3; p++)
      for (int k = 1; k < 3; k++) begin
        int fv = (k == 1) ? 5 : 6;
        run(1, 16'h5A00 + 16'(p), 16'h0, 0, p, fv, 16'h6C39 ^ 16'(p << 4), 0);
      end
    // R6 skipped final acknowledge
    run(0, 16'h0042, 16'h8000, 1, -1, 0, 16'h0, 0);
    run(0, 16'h0042, 16'h8000, 1, 4, 6, 16'h0, 0);
    run(0, 16'h0042, 16'h8000, 1, 2, 6, 16'h0, 0);
    // R9 request while busy is ignored
    run(0, 16'h3C3C, 16'h0F0F, 0, -1, 0, 16'h0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule